// File: doc/BRIEF.md
# Configuration Register Access Checker

This block stands in front of the configuration register storage of one device. It checks every access before the access reaches storage, and it steers the access to the correct bytes. A request carries a path flag (I/O-port style or memory-mapped), a 12-bit byte offset, a size code and right-justified write data. The low part of the space accepts narrow and full-width accesses over either path. The upper part accepts only full 32-bit memory-mapped accesses. One 32-bit slot holds the address-pointer register, and that slot takes only full 32-bit accesses.

Legal accesses go to a 32-bit-wide store. Bytes are placed little-endian, so byte address N within a 32-bit slot maps to bits 8*(N mod 4) and up. Each write keeps the reserved bits of the target slot at their old value. The block does this in hardware with a read-modify-write pipeline, so software never needs to merge reserved bits itself. The address-pointer slot has no reserved bits, so every bit of it takes the new value. An illegal request returns an error flag with all-ones data and does not change storage.

Every request is answered in the cycle after it is accepted. Requests may be issued back to back, and a read that directly follows a write to the same slot sees the new value.

Top module: `cfg_access_gate`

## Requirements
- R1: The size code is 0 for a byte, 1 for a 16-bit word, 2 for a 32-bit word, and 3 is always illegal. For offsets below 256, any legal size that is aligned is accepted on either path (`req_mmio` 0 or 1), except in the address-pointer slot.
- R2: Offsets 256 to 4095 are accepted only when `req_mmio`=1, the size code is 2 and the offset is 4-byte aligned. Any other access to these offsets is an error.
- R3: The address-pointer slot covers offsets 248 to 251. Any access there whose size code is not 2 is an error.
- R4: A word access with offset bit 0 set is an error. A 32-bit access with offset bits [1:0] not equal to 0 is an error.
- R5: An erroneous access sets `resp_err`, returns 32'hFFFFFFFF on `resp_rdata`, and leaves storage unchanged.
- R6: Each accepted request gives `resp_valid` high in exactly the following cycle. Read data is right-justified and zero-extended to the access width. The byte at offset N is `resp_rdata[7:0]`, and for a word the byte at N+1 is bits [15:8].
- R7: A write changes only the bytes it addresses. `req_wdata[7:0]` goes to the lowest addressed byte, and data bits above the access width are ignored.
- R8: On a write, bits set in the reserved mask keep their old value. The mask is 32'hFF000000 for slots below offset 256 and 32'h0000F000 for slots at 256 and above. The address-pointer slot has no reserved bits.
- R9: While reset is applied and right after reset, `resp_valid` and `resp_err` are low.
- R10: A read that immediately follows a write to the same slot returns the merged value of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mmio | input | 1 | 1 = memory-mapped path, 0 = I/O-port style path |
| req_offset | input | 12 | Byte offset within the device space |
| req_size | input | 2 | 0 byte, 1 word, 2 32-bit, 3 illegal |
| req_wdata | input | 32 | Write data, right-justified |
| resp_valid | output | 1 | Response for the request of the previous cycle |
| resp_err | output | 1 | The request was illegal |
| resp_rdata | output | 32 | Read data, right-justified, or all-ones on error |

## Verification
The bound checker checks on every cycle the rules that map a request to an error or to acceptance: the upper region, the address-pointer slot, alignment, and the acceptance of legal low-region accesses. It also checks the one-cycle response timing, the all-ones data on error, the zero-extension of byte reads, and the rule that no committed write changes a reserved bit. Other behaviours need a known history, and only the bench's scenarios can show them. These are the little-endian placement of bytes in a slot, the rule that a write touches only its lanes, the forwarding of a write to the read that directly follows it, and the fact that a rejected write leaves the stored value intact.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;
  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / 8;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_BAD   = 2'd3
  } acc_size_e;

  // lanes touched by an access of a given size at a given byte position
  function automatic logic [LANES-1:0] lanes_for(input logic [1:0] sz,
                                                 input logic [LANE_W-1:0] lo);
    logic [LANES-1:0] r;
    case (sz)
      SZ_BYTE: r = LANES'(1) << lo;
      SZ_WORD: r = LANES'(3) << lo;
      default: r = '1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cfg_gate_decode.sv
module cfg_gate_decode
  import cfg_gate_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int LOW_LIMIT = 256,
  parameter int CADDR_OFF = 248
) (
  input  logic             mmio,
  input  logic [OFF_W-1:0] offset,
  input  logic [1:0]       size,
  output logic             legal,
  output logic             hi_region,
  output logic             is_caddr,
  output logic [LANES-1:0] lanes
);
  localparam logic [OFF_W-1:0]      LOW_LIM_V = OFF_W'(LOW_LIMIT);
  localparam logic [OFF_W-LANE_W-1:0] CADDR_SLOT = (OFF_W-LANE_W)'(CADDR_OFF / LANES);

  logic aligned, size_ok, hi_ok, caddr_ok;

  always_comb begin
    size_ok   = (size != SZ_BAD);
    case (size)
      SZ_BYTE:  aligned = 1'b1;
      SZ_WORD:  aligned = ~offset[0];
      default:  aligned = (offset[LANE_W-1:0] == '0);
    endcase
    hi_region = (offset >= LOW_LIM_V);
    hi_ok     = ~hi_region | (mmio & (size == SZ_DWORD));
    is_caddr  = (offset[OFF_W-1:LANE_W] == CADDR_SLOT);
    caddr_ok  = ~is_caddr | (size == SZ_DWORD);
    legal     = size_ok & aligned & hi_ok & caddr_ok;
    lanes     = lanes_for(size, offset[LANE_W-1:0]);
  end
endmodule

// File: rtl/cfg_gate_store.sv
module cfg_gate_store #(
  parameter int DATA_W = 32,
  parameter int AW     = 10,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual port, read-first; the caller forwards same-slot collisions
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cfg_gate_merge.sv
module cfg_gate_merge
  import cfg_gate_pkg::*;
(
  input  logic [BUS_W-1:0]  old_data,
  input  logic [BUS_W-1:0]  new_data,
  input  logic [LANE_W-1:0] lo,
  input  logic [LANES-1:0]  lanes,
  input  logic [BUS_W-1:0]  rsvd_mask,
  output logic [BUS_W-1:0]  merged
);
  logic [BUS_W-1:0] placed, lane_bits, image;

  always_comb begin
    placed = new_data << {lo, 3'b000};
    for (int i = 0; i < LANES; i++) lane_bits[8*i +: 8] = {8{lanes[i]}};
    image  = (old_data & ~lane_bits) | (placed & lane_bits);
    merged = (old_data & rsvd_mask) | (image & ~rsvd_mask);
  end
endmodule

// File: rtl/cfg_gate_align.sv
module cfg_gate_align
  import cfg_gate_pkg::*;
(
  input  logic [BUS_W-1:0]  slot_data,
  input  logic [LANE_W-1:0] lo,
  input  logic [1:0]        size,
  input  logic              err,
  output logic [BUS_W-1:0]  rdata
);
  logic [BUS_W-1:0] shifted;

  always_comb begin
    shifted = slot_data >> {lo, 3'b000};
    if (err) rdata = '1;
    else begin
      case (size)
        SZ_BYTE: rdata = {{(BUS_W-8){1'b0}},  shifted[7:0]};
        SZ_WORD: rdata = {{(BUS_W-16){1'b0}}, shifted[15:0]};
        default: rdata = shifted;
      endcase
    end
  end
endmodule

// File: rtl/cfg_access_gate.sv
module cfg_access_gate
  import cfg_gate_pkg::*;
#(
  parameter int          OFF_W     = 12,
  parameter int          LOW_LIMIT = 256,
  parameter int          CADDR_OFF = 248,
  parameter logic [31:0] RSVD_LOW  = 32'hFF00_0000,
  parameter logic [31:0] RSVD_HIGH = 32'h0000_F000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_mmio,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  output logic             resp_valid,
  output logic             resp_err,
  output logic [31:0]      resp_rdata
);
  localparam int AW = OFF_W - LANE_W;

  logic             legal, hi_region, is_caddr;
  logic [LANES-1:0] lanes;
  logic [AW-1:0]    req_slot;
  logic [BUS_W-1:0] req_mask;

  cfg_gate_decode #(.OFF_W(OFF_W), .LOW_LIMIT(LOW_LIMIT), .CADDR_OFF(CADDR_OFF)) u_dec (
    .mmio(req_mmio), .offset(req_offset), .size(req_size),
    .legal(legal), .hi_region(hi_region), .is_caddr(is_caddr), .lanes(lanes)
  );

  always_comb begin
    req_slot = req_offset[OFF_W-1:LANE_W];
    if (is_caddr)       req_mask = '0;
    else if (hi_region) req_mask = RSVD_HIGH;
    else                req_mask = RSVD_LOW;
  end

  // stage 1: request registered, old slot content arriving from storage
  logic              s1_valid, s1_err, s1_write;
  logic [AW-1:0]     s1_slot;
  logic [LANE_W-1:0] s1_lo;
  logic [1:0]        s1_size;
  logic [LANES-1:0]  s1_lanes;
  logic [BUS_W-1:0]  s1_wdata, s1_mask;
  logic              fwd_hit;
  logic [BUS_W-1:0]  fwd_data;
  logic [BUS_W-1:0]  rd_data, old_data, merged;
  logic              wr_en;

  assign wr_en    = s1_valid & s1_write & ~s1_err;
  assign old_data = fwd_hit ? fwd_data : rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_err   <= 1'b0;
      s1_write <= 1'b0;
      fwd_hit  <= 1'b0;
    end else begin
      s1_valid <= req_valid;
      s1_err   <= req_valid & ~legal;
      s1_write <= req_write;
      fwd_hit  <= wr_en & (s1_slot == req_slot);
    end
    s1_slot  <= req_slot;
    s1_lo    <= req_offset[LANE_W-1:0];
    s1_size  <= req_size;
    s1_lanes <= lanes;
    s1_wdata <= req_wdata;
    s1_mask  <= req_mask;
    fwd_data <= merged;
  end

  cfg_gate_store #(.DATA_W(BUS_W), .AW(AW)) u_store (
    .clk(clk),
    .rd_en(req_valid), .rd_addr(req_slot), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(s1_slot), .wr_data(merged)
  );

  cfg_gate_merge u_merge (
    .old_data(old_data), .new_data(s1_wdata), .lo(s1_lo),
    .lanes(s1_lanes), .rsvd_mask(s1_mask), .merged(merged)
  );

  cfg_gate_align u_align (
    .slot_data(old_data), .lo(s1_lo), .size(s1_size),
    .err(s1_err), .rdata(resp_rdata)
  );

  assign resp_valid = s1_valid;
  assign resp_err   = s1_err;
endmodule

// File: rtl/cfg_gate_chk.sv
module cfg_gate_chk #(
  parameter int OFF_W     = 12,
  parameter int LOW_LIMIT = 256,
  parameter int CADDR_OFF = 248
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_mmio,
  input logic [OFF_W-1:0] req_offset,
  input logic [1:0]       req_size,
  input logic             resp_valid,
  input logic             resp_err,
  input logic [31:0]      resp_rdata,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic [31:0]      old_data,
  input logic [31:0]      rsvd_mask
);
  localparam logic [OFF_W-1:0]   LIM  = OFF_W'(LOW_LIMIT);
  localparam logic [OFF_W-3:0]   CSLT = (OFF_W-2)'(CADDR_OFF / 4);

  logic in_hi, in_caddr, misal;
  assign in_hi    = req_offset >= LIM;
  assign in_caddr = req_offset[OFF_W-1:2] == CSLT;
  assign misal    = (req_size == 2'd1 && req_offset[0]) ||
                    (req_size == 2'd2 && req_offset[1:0] != 2'd0);

  AST_RESP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid); // R6
  AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid); // R6
  AST_LOW_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !in_hi && !in_caddr && !misal && req_size != 2'd3) |=> !resp_err); // R1
  AST_HIGH_MMIO_FULL: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_hi && (!req_mmio || req_size != 2'd2)) |=> resp_err); // R2
  AST_CADDR_FULL: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_caddr && req_size != 2'd2) |=> resp_err); // R3
  AST_ALIGN_REQ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && misal) |=> resp_err); // R4
  AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_err) |-> resp_rdata == 32'hFFFF_FFFF); // R5
  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_err && $past(req_size) == 2'd0) |-> resp_rdata[31:8] == 24'd0); // R6
  AST_RSVD_KEPT: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((wr_data ^ old_data) & rsvd_mask) == 32'd0); // R8
endmodule

bind cfg_access_gate cfg_gate_chk #(.OFF_W(OFF_W), .LOW_LIMIT(LOW_LIMIT), .CADDR_OFF(CADDR_OFF)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_mmio(req_mmio),
  .req_offset(req_offset), .req_size(req_size), .resp_valid(resp_valid),
  .resp_err(resp_err), .resp_rdata(resp_rdata), .wr_en(wr_en),
  .wr_data(merged), .old_data(old_data), .rsvd_mask(s1_mask)
);

// File: tb/cfg_access_gate_test.sv
module cfg_access_gate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_mmio = 1'b0;
  logic [11:0] req_offset = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        resp_valid, resp_err;
  logic [31:0] resp_rdata;

  int errs = 0;
  int total = 0;

  localparam logic [31:0] MLO = 32'hFF00_0000;
  localparam logic [31:0] MHI = 32'h0000_F000;

  always #5 clk = ~clk;

  cfg_access_gate uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_mmio(req_mmio), .req_offset(req_offset), .req_size(req_size),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_err(resp_err),
    .resp_rdata(resp_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request at a falling edge, collect its response one cycle later
  task automatic acc(input logic w, input logic mm, input logic [11:0] off,
                     input logic [1:0] sz, input logic [31:0] wd,
                     output logic [31:0] rd, output logic er);
    req_valid = 1'b1; req_write = w; req_mmio = mm;
    req_offset = off; req_size = sz; req_wdata = wd;
    @(negedge clk);
    check("R6 response valid", {31'd0, resp_valid}, 32'd1);
    rd = resp_rdata; er = resp_err;
    req_valid = 1'b0;
  endtask

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n,
                                      input logic [31:0] m);
    return (o & m) | (n & ~m);
  endfunction

  task automatic t_reset();
    check("R9 resp_valid in reset", {31'd0, resp_valid}, 32'd0);
    check("R9 resp_err in reset", {31'd0, resp_err}, 32'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R9 resp_valid after reset", {31'd0, resp_valid}, 32'd0);
    check("R9 resp_err after reset", {31'd0, resp_err}, 32'd0);
  endtask

  task automatic t_low_dword();
    logic [31:0] r0, r; logic e;
    acc(0, 0, 12'h010, 2, 0, r0, e); check("R1 io dword read ok", {31'd0, e}, 0);
    acc(1, 0, 12'h010, 2, 32'hA1B2_C3D4, r, e); check("R1 io dword write ok", {31'd0, e}, 0);
    acc(0, 1, 12'h010, 2, 0, r, e);
    check("R10 R8 readback merged", r, mrg(r0, 32'hA1B2_C3D4, MLO));
  endtask

  task automatic t_endian();
    logic [31:0] r, b; logic e;
    acc(0, 0, 12'h010, 2, 0, r, e);
    for (int k = 0; k < 4; k++) begin
      acc(0, 0, 12'h010 + 12'(k), 0, 0, b, e);
      check("R6 byte lane little-endian", b, (r >> (8*k)) & 32'hFF);
    end
    acc(0, 1, 12'h012, 1, 0, b, e);
    check("R6 upper word", b, r >> 16);
    acc(0, 0, 12'h010, 1, 0, b, e);
    check("R6 lower word", b, r & 32'hFFFF);
  endtask

  task automatic t_lanes();
    logic [31:0] r, r2, x; logic e;
    acc(0, 0, 12'h010, 2, 0, r, e);
    acc(1, 0, 12'h011, 0, 32'hFFFF_FF5A, x, e); check("R7 byte write ok", {31'd0, e}, 0);
    acc(0, 0, 12'h010, 2, 0, r2, e);
    check("R7 byte write one lane", r2, (r & ~32'h0000_FF00) | 32'h0000_5A00);
    acc(1, 1, 12'h012, 1, 32'hAAAA_7788, x, e);
    acc(0, 0, 12'h010, 2, 0, r, e);
    check("R7 R8 word write upper half", r,
          mrg(r2, (r2 & 32'h0000_FFFF) | 32'h7788_0000, MLO));
  endtask

  task automatic t_high();
    logic [31:0] r0, r, x; logic e;
    acc(0, 1, 12'h400, 2, 0, r0, e); check("R2 mmio dword read ok", {31'd0, e}, 0);
    acc(1, 1, 12'h400, 2, 32'h1234_5678, x, e);
    acc(0, 1, 12'h400, 2, 0, r, e);
    check("R8 high mask readback", r, mrg(r0, 32'h1234_5678, MHI));
    acc(0, 0, 12'h400, 2, 0, x, e); check("R2 io high error", {31'd0, e}, 1);
    check("R5 error data ones", x, 32'hFFFF_FFFF);
    acc(0, 1, 12'h400, 1, 0, x, e); check("R2 mmio word high error", {31'd0, e}, 1);
    acc(0, 1, 12'h100, 0, 0, x, e); check("R2 boundary byte 256 error", {31'd0, e}, 1);
    acc(1, 0, 12'h400, 2, 32'hDEAD_BEEF, x, e); check("R5 io high write error", {31'd0, e}, 1);
    acc(0, 1, 12'h400, 2, 0, x, e);
    check("R5 dropped write", x, r);
    acc(0, 1, 12'hFFC, 2, 0, r0, e);
    acc(1, 1, 12'hFFC, 2, 32'h0F0F_0F0F, x, e);
    acc(0, 1, 12'hFFC, 2, 0, r, e);
    check("R2 top slot writable", r, mrg(r0, 32'h0F0F_0F0F, MHI));
  endtask

  task automatic t_caddr();
    logic [31:0] r, x; logic e;
    acc(1, 0, 12'h0F8, 2, 32'h8000_1234, x, e); check("R3 caddr dword ok", {31'd0, e}, 0);
    acc(0, 0, 12'h0F8, 2, 0, r, e);
    check("R8 caddr no reserved bits", r, 32'h8000_1234);
    acc(1, 0, 12'h0F9, 0, 32'h55, x, e); check("R3 caddr byte write error", {31'd0, e}, 1);
    acc(0, 1, 12'h0F8, 1, 0, x, e); check("R3 caddr word read error", {31'd0, e}, 1);
    check("R5 caddr error data", x, 32'hFFFF_FFFF);
    acc(0, 0, 12'h0F8, 2, 0, r, e);
    check("R5 caddr unchanged", r, 32'h8000_1234);
  endtask

  task automatic t_align();
    logic [31:0] r, x; logic e;
    acc(1, 0, 12'h020, 2, 32'h00CA_FE01, x, e);
    acc(0, 0, 12'h020, 2, 0, r, e);
    acc(0, 0, 12'h021, 1, 0, x, e); check("R4 odd word error", {31'd0, e}, 1);
    acc(0, 1, 12'h022, 2, 0, x, e); check("R4 misaligned dword error", {31'd0, e}, 1);
    acc(0, 0, 12'h020, 3, 0, x, e); check("R1 size 3 error", {31'd0, e}, 1);
    acc(1, 0, 12'h023, 1, 32'h9999, x, e); check("R4 misaligned write error", {31'd0, e}, 1);
    acc(0, 0, 12'h020, 2, 0, x, e); check("R5 misaligned write dropped", x, r);
    acc(0, 0, 12'h0FF, 0, 0, x, e); check("R1 last low byte ok", {31'd0, e}, 0);
    check("R6 byte zero-extended", x & 32'hFFFF_FF00, 0);
  endtask

  initial begin
    #(200000 * 10);
    errs++; total++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_low_dword();
    t_endian();
    t_lanes();
    t_high();
    t_caddr();
    t_align();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule